// File: doc/BRIEF.md
# Event Countdown Timer with Timestamp

This peripheral pairs a loadable down-counter, which raises a sticky expiry flag, with a free-running up-counting timestamp. Both advance on a single-cycle tick enable, nominally 1 MHz, that is generated outside the block. A plain register port gives software access. A write loads the count. A control byte write selects run, periodic and reload, and it also acknowledges the expiry flag.

A typical event sequence runs as follows. Software writes the control byte with only the flag bit set, which stops the counter and acknowledges any pending event in one access. It then loads the count and writes the flag bit together with the run bit. When the count expires, the flag sets and the level interrupt rises. The flag also serves as the source indication on a shared interrupt line. In one-shot mode the counter then stops at zero. With periodic and reload both selected, it restarts from the last loaded value.

Top module: `evt_timer`

## Requirements
- R1: After reset the count, the loaded value, the timestamp, every control bit and `irq` are 0. Reads of offsets 0x00, 0x08 and 0x14 all return 0.
- R2: A write to offset 0x00 loads the full 32-bit count on that clock edge, whether or not the timer is running. Such a write wins over a tick in the same cycle, and offset 0x00 reads back the current count.
- R3: On each cycle with `tick` high and the run bit (control bit 0) set, a count above 1 decrements by exactly one. Without a tick, or with run clear, the count holds. Loads from 0xF through 0xFFFFFFFF work.
- R4: The tick that finds the running count at 1 or 0 is the expiry. On that clock edge the flag (control bit 7) sets. Unless periodic mode and reload are both set, run clears and the count becomes 0 and stays there.
- R5: The flag stays set until a control write has bit 7 = 1. A control write with bit 7 = 0 leaves it alone. An expiry in the same cycle as a clearing write leaves the flag set.
- R6: A control write of 0x80 clears the flag and stops the counter. A later tick leaves the count unchanged.
- R7: A control write of 0x81 clears any pending flag and starts counting down from the count currently held.
- R8: With periodic mode (bit 1) and reload (bit 2) both set, an expiry reloads the last value written to offset 0x00, run stays set, and the flag sets on every expiry.
- R9: The timestamp at offset 0x08 increments by one on every tick, whether or not the timer is running. It wraps modulo 2^STAMP_W, and writes to it are ignored.
- R10: `irq` is high exactly while the flag is set. It is a level, not a pulse.
- R11: Reads are registered, and `rdata` is valid on the edge after `rd_en`. The control read layout is bit 0 run, bit 1 periodic, bit 2 reload, bit 7 flag, with all other bits 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count enable (nominally 1 MHz) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data; control uses bits 7:0 |
| rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, high while the flag is set |

## Verification
The bench builds the block with DATA_W = 32 and ADDR_W = 5, so the full-width count is exercised, including a load of 0xFFFFFFFF and the minimum load of 0xF. STAMP_W is reduced to 8, which brings the timestamp wrap within reach after 256 ticks. A cycle-by-cycle reference model of the flag is compared against `irq` on every cycle. This confirms that expiry lands on the exact tick edge, including the cases where a tick coincides with a clearing write or with a count load.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // register byte offsets
  localparam int unsigned OFS_COUNT = 32'h00;
  localparam int unsigned OFS_STAMP = 32'h08;
  localparam int unsigned OFS_CTRL  = 32'h14;

  // control byte bit positions
  localparam int CB_RUN  = 0;
  localparam int CB_PER  = 1;
  localparam int CB_RLD  = 2;
  localparam int CB_DONE = 7;

  typedef struct packed {
    logic done;
    logic rld;
    logic per;
    logic run;
  } ctrl_t;

  function automatic logic [7:0] ctrl_byte(ctrl_t c);
    logic [7:0] b;
    b          = '0;
    b[CB_RUN]  = c.run;
    b[CB_PER]  = c.per;
    b[CB_RLD]  = c.rld;
    b[CB_DONE] = c.done;
    return b;
  endfunction

endpackage

// File: rtl/evt_stamp.sv
module evt_stamp #(
  parameter int STAMP_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  output logic [STAMP_W-1:0] stamp
);

  always_ff @(posedge clk) begin
    if (rst)       stamp <= '0;
    else if (tick) stamp <= stamp + STAMP_W'(1);
  end

  // R9
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> stamp == $past(stamp) + STAMP_W'(1));

  // R9
  stamp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(stamp));

endmodule

// File: rtl/evt_regs.sv
module evt_regs
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] load,
  output logic              wr_count
);

  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

  logic ctrl_wr;
  logic reload_mode;

  assign wr_count    = wr_en && (addr == A_COUNT);
  assign ctrl_wr     = wr_en && (addr == A_CTRL);
  assign reload_mode = ctrl.per && ctrl.rld;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      load <= '0;
    end else begin
      if (wr_count) load <= wdata;
      if (ctrl_wr) begin
        ctrl.run <= wdata[CB_RUN];
        ctrl.per <= wdata[CB_PER];
        ctrl.rld <= wdata[CB_RLD];
      end else if (expire && !reload_mode) begin
        ctrl.run <= 1'b0;
      end
      // a new expiry outranks an acknowledge in the same cycle
      if (expire)                        ctrl.done <= 1'b1;
      else if (ctrl_wr && wdata[CB_DONE]) ctrl.done <= 1'b0;
    end
  end

  // R4
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> ctrl.done);

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.done && !(ctrl_wr && wdata[CB_DONE])) |=> ctrl.done);

  // R6
  stop_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[7:0] == 8'h80 && !expire) |=> (!ctrl.run && !ctrl.done));

  // R8
  periodic_run_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && reload_mode && !ctrl_wr) |=> ctrl.run);

endmodule

// File: rtl/evt_countdown.sv
module evt_countdown #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              reload_mode,
  input  logic              wr_count,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] load,
  output logic [DATA_W-1:0] count,
  output logic              expire
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic step;

  assign step   = tick && run && !wr_count;
  assign expire = step && (count <= ONE);

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (wr_count) count <= wdata;
    else if (expire)   count <= reload_mode ? load : '0;
    else if (step)     count <= count - ONE;
  end

  // R2
  wr_take_chk: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> count == $past(wdata));

  // R3
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && count > ONE) |=> count == $past(count) - ONE);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_count && !(tick && run)) |=> $stable(count));

  // R4
  oneshot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !reload_mode) |=> count == '0);

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && reload_mode) |=> count == $past(load));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int STAMP_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_STAMP = ADDR_W'(OFS_STAMP);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);

  ctrl_t               ctrl;
  logic [DATA_W-1:0]   load;
  logic [DATA_W-1:0]   count;
  logic [STAMP_W-1:0]  stamp;
  logic                wr_count;
  logic                expire;

  evt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .expire   (expire),
    .ctrl     (ctrl),
    .load     (load),
    .wr_count (wr_count)
  );

  evt_countdown #(.DATA_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .run         (ctrl.run),
    .reload_mode (ctrl.per && ctrl.rld),
    .wr_count    (wr_count),
    .wdata       (wdata),
    .load        (load),
    .count       (count),
    .expire      (expire)
  );

  evt_stamp #(.STAMP_W(STAMP_W)) u_stamp (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .stamp (stamp)
  );

  // the flag is itself a flop, so the interrupt is a registered level
  assign irq = ctrl.done;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        A_COUNT: rdata <= count;
        A_STAMP: rdata <= DATA_W'(stamp);
        A_CTRL:  rdata <= DATA_W'(ctrl_byte(ctrl));
        default: rdata <= '0;
      endcase
    end
  end

  // R11
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != A_COUNT && addr != A_STAMP && addr != A_CTRL) |=> rdata == '0);

  // R11
  rd_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_COUNT) |=> rdata == $past(count));

endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;

  localparam int CLK_P   = 10;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int STAMP_W = 8;

  localparam logic [7:0] OP_W = 8'd0;  // write addr, data
  localparam logic [7:0] OP_R = 8'd1;  // read addr, compare exp
  localparam logic [7:0] OP_T = 8'd2;  // data ticks
  localparam logic [7:0] OP_I = 8'd3;  // compare irq with exp

  function automatic logic [87:0] e(logic [7:0] op, logic [7:0] a,
                                    logic [31:0] d, logic [31:0] x, logic [7:0] r);
    return {op, a, d, x, r};
  endfunction

  localparam int NV = 72;
  localparam logic [87:0] VEC [NV] = '{
    // R1 reset state
    e(OP_R,8'h00,0,0,1), e(OP_R,8'h14,0,0,1), e(OP_R,8'h08,0,0,1), e(OP_I,0,0,0,1),
    // R2 load, R3 hold while stopped, R9 stamp
    e(OP_W,8'h00,32'h10,0,2), e(OP_R,8'h00,0,32'h10,2), e(OP_T,0,3,0,3),
    e(OP_R,8'h00,0,32'h10,3), e(OP_R,8'h08,0,3,9),
    // R7 start, R3 decrement, R11 ctrl layout
    e(OP_W,8'h14,32'h81,0,7), e(OP_T,0,4,0,3), e(OP_R,8'h00,0,32'h0C,3),
    e(OP_R,8'h14,0,32'h01,11),
    // R2 load while running, R4 expiry at minimum load 0xF
    e(OP_W,8'h00,32'h0F,0,2), e(OP_R,8'h00,0,32'h0F,2), e(OP_T,0,14,0,3),
    e(OP_R,8'h00,0,1,3), e(OP_I,0,0,0,4), e(OP_T,0,1,0,4), e(OP_I,0,0,1,10),
    e(OP_R,8'h14,0,32'h80,4), e(OP_R,8'h00,0,0,4), e(OP_T,0,5,0,4),
    e(OP_R,8'h00,0,0,4), e(OP_I,0,0,1,5),
    // R5 write without bit 7 keeps flag, R6 0x80 acks
    e(OP_W,8'h14,0,0,5), e(OP_I,0,0,1,5), e(OP_R,8'h14,0,32'h80,5),
    e(OP_W,8'h14,32'h80,0,6), e(OP_I,0,0,0,6), e(OP_R,8'h14,0,0,6),
    // R6 stop mid-count
    e(OP_W,8'h00,32'h20,0,2), e(OP_W,8'h14,32'h81,0,7), e(OP_T,0,2,0,3),
    e(OP_R,8'h00,0,32'h1E,3), e(OP_W,8'h14,32'h80,0,6), e(OP_T,0,3,0,6),
    e(OP_R,8'h00,0,32'h1E,6),
    // R8 periodic reload
    e(OP_W,8'h00,3,0,8), e(OP_W,8'h14,32'h87,0,8), e(OP_T,0,3,0,8),
    e(OP_I,0,0,1,8), e(OP_R,8'h00,0,3,8), e(OP_R,8'h14,0,32'h87,8),
    e(OP_T,0,1,0,8), e(OP_R,8'h00,0,2,8), e(OP_W,8'h14,32'h87,0,7),
    e(OP_I,0,0,0,7), e(OP_T,0,2,0,8), e(OP_I,0,0,1,8), e(OP_R,8'h00,0,3,8),
    // R4 periodic without reload acts one-shot
    e(OP_W,8'h14,32'h83,0,4), e(OP_T,0,3,0,4), e(OP_R,8'h14,0,32'h82,4),
    e(OP_R,8'h00,0,0,4),
    // R3 maximum load
    e(OP_W,8'h00,32'hFFFFFFFF,0,3), e(OP_W,8'h14,32'h81,0,3), e(OP_T,0,1,0,3),
    e(OP_R,8'h00,0,32'hFFFFFFFE,3), e(OP_W,8'h14,32'h80,0,6),
    // R9 stamp write ignored, R11 unmapped
    e(OP_W,8'h08,32'h55,0,9), e(OP_R,8'h08,0,32'h2A,9), e(OP_R,8'h04,0,0,11),
    // R4 zero count expires on first tick
    e(OP_W,8'h00,0,0,4), e(OP_W,8'h14,32'h81,0,4), e(OP_T,0,1,0,4),
    e(OP_I,0,0,1,4), e(OP_R,8'h14,0,32'h80,4),
    // R9 wrap
    e(OP_T,0,213,0,9), e(OP_R,8'h08,0,0,9), e(OP_T,0,1,0,9), e(OP_R,8'h08,0,1,9)
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic irq;

  int n_tests = 0;
  int n_fail  = 0;
  int wd      = 0;
  int m_bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAMP_W(STAMP_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // reference model of the flag, built from R2..R8
  logic [31:0] m_cnt = 0, m_load = 0;
  logic m_run = 0, m_per = 0, m_rld = 0, m_done = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_cnt <= 0; m_load <= 0; m_run <= 0; m_per <= 0; m_rld <= 0; m_done <= 0;
    end else begin
      automatic logic wc = wr_en && addr == 5'h00;
      automatic logic wk = wr_en && addr == 5'h14;
      automatic logic ex = tick && m_run && !wc && m_cnt <= 1;
      if (wc) begin m_cnt <= wdata; m_load <= wdata; end
      else if (ex) m_cnt <= (m_per && m_rld) ? m_load : 0;
      else if (tick && m_run) m_cnt <= m_cnt - 1;
      if (wk) begin m_run <= wdata[0]; m_per <= wdata[1]; m_rld <= wdata[2]; end
      else if (ex && !(m_per && m_rld)) m_run <= 0;
      if (ex) m_done <= 1;
      else if (wk && wdata[7]) m_done <= 0;
    end
  end

  // R10 irq compared with the model on every cycle
  always @(negedge clk) if (!rst && irq !== m_done) m_bad++;

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired: got %0d cycles exp < 20000", wd);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d got %h exp %h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic t,
                     input logic [7:0] a, input logic [31:0] d);
    wr_en = w; rd_en = r; tick = t; addr = a[ADDR_W-1:0]; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; tick = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      automatic logic [7:0]  op = VEC[i][87:80];
      automatic logic [7:0]  a  = VEC[i][79:72];
      automatic logic [31:0] d  = VEC[i][71:40];
      automatic logic [31:0] x  = VEC[i][39:8];
      automatic int          r  = int'(VEC[i][7:0]);
      case (op)
        OP_W: cyc(1, 0, 0, a, d);
        OP_R: begin cyc(0, 1, 0, a, 0); check(r, rdata, x); end
        OP_T: for (int k = 0; k < int'(d); k++) cyc(0, 0, 1, 0, 0);
        default: check(r, {31'b0, irq}, x);
      endcase
    end

    // R5 expiry and clearing write in the same cycle: flag stays
    cyc(1, 0, 0, 8'h00, 2); cyc(1, 0, 0, 8'h14, 32'h81); cyc(0, 0, 1, 0, 0);
    cyc(1, 0, 1, 8'h14, 32'h80);
    check(5, {31'b0, irq}, 1);
    cyc(0, 1, 0, 8'h14, 0); check(5, rdata, 32'h80);
    cyc(1, 0, 0, 8'h14, 32'h80);

    // R2 load wins over a tick in the same cycle
    cyc(1, 0, 0, 8'h00, 5); cyc(1, 0, 0, 8'h14, 32'h81);
    cyc(1, 0, 1, 8'h00, 9);
    cyc(0, 1, 0, 8'h00, 0); check(2, rdata, 9);
    cyc(1, 0, 0, 8'h14, 32'h80);

    // R1 reset mid-run with flag set
    cyc(1, 0, 0, 8'h00, 1); cyc(1, 0, 0, 8'h14, 32'h81); cyc(0, 0, 1, 0, 0);
    check(10, {31'b0, irq}, 1);
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    check(1, {31'b0, irq}, 0);
    cyc(0, 1, 0, 8'h00, 0); check(1, rdata, 0);
    cyc(0, 1, 0, 8'h14, 0); check(1, rdata, 0);
    cyc(0, 1, 0, 8'h08, 0); check(1, rdata, 0);

    // R10 cycle-accurate irq against the reference model
    check(10, m_bad, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule